// File: doc/BRIEF.md
# Programmable AND-OR Product Term Array

This block is the configurable logic core of a sum-of-products engine. Twenty-two input signals (twelve dedicated inputs and ten feedback inputs) are each offered to the array in true and inverted form, which gives 44 array lines. Every product term holds one row of connection bits. The term is the AND of the lines whose bits are set. Product terms are ORed in fixed groups of unequal size, and each group drives one of ten sum outputs. A separate set of control terms supplies per-output enables and the global preset, clear and clock terms.

The connection map is written over a one-bit valid/ready stream. A pulse on `erase` opens every connection and enters load mode. Bits are then streamed row after row, and a pulse on `commit` leaves load mode and switches evaluation on. The stream follows the usual handshake. A bit moves only in a cycle where `cfg_valid` and `cfg_ready` are both high. The source may raise or drop `cfg_valid` in any cycle. `cfg_ready` is high only in load mode while rows remain unfilled, so the block applies back-pressure once the last row has been written. Evaluation stays off during reset and for the whole of load mode, and every term output reads 0 while it is off.

Top module: `pla_and_or_array`

## Requirements
- R1: After reset, `cfg_ready` is 0, evaluation is off, and all of `sum_out`, `oe_out`, `preset_term`, `clear_term` and `clock_term` are 0.
- R2: A pulse on `erase` clears every connection bit and enters load mode. From the next cycle `cfg_ready` is 1, and all term outputs stay 0 until a commit.
- R3: The array has 44 lines. Signal k is `in_ded[k]` for k < 12 and `in_fb[k-12]` for k ≥ 12. Line 2k carries signal k and line 2k+1 carries its inverse. A connection bit of 1 means the line is connected. Each row takes 44 accepted bits, and the first accepted bit belongs to line 0. Rows are filled in order from row 0 to row 132.
- R4: Once all 133 rows are written, `cfg_ready` falls to 0. Bits offered after that point change nothing.
- R5: A `commit` pulse in load mode ends loading, and evaluation is on from the next cycle. The bits of a row that was not completed are discarded, and rows never written stay open. A `commit` outside load mode has no effect.
- R6: A product term is 1 exactly when every line connected to it is 1.
- R7: A term connected to both the true and the inverted line of one signal is always 0.
- R8: A term with no connections is always 1, so committing straight after an erase drives every output to 1.
- R9: Rows 0 to 119 are sum terms, grouped in consecutive blocks. `sum_out[0]` to `sum_out[9]` take 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 rows respectively, starting at row 0, and each sum output is the OR of its block.
- R10: Row 120+o drives `oe_out[o]`. Row 130 drives `preset_term`, row 131 drives `clear_term` and row 132 drives `clock_term`.
- R11: A row with all 44 bits set is always 0, so an unused term does not affect its sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase | input | 1 | Bulk erase and enter load mode |
| commit | input | 1 | End load mode and enable evaluation |
| cfg_valid | input | 1 | Configuration bit valid |
| cfg_ready | output | 1 | Block can take a configuration bit |
| cfg_data | input | 1 | Configuration bit (1 = connected) |
| in_ded | input | 12 | Dedicated input signals |
| in_fb | input | 10 | Feedback input signals |
| sum_out | output | 10 | OR of each product-term group |
| oe_out | output | 10 | Per-output enable terms |
| preset_term | output | 1 | Global preset term |
| clear_term | output | 1 | Global clear term |
| clock_term | output | 1 | Clock term |

## Verification
The assertions assume that `erase` and `commit` are single-cycle pulses, that they never arrive in the same cycle, and that `cfg_data` is a known value whenever `cfg_valid` is high. The bench changes every input on the falling clock edge. It pulses the control inputs for one cycle only, and it counts a bit as moved only when it sees `cfg_ready` high together with its own `cfg_valid`. This keeps the reference model of the map in step with the rows the block has actually written, even when `cfg_valid` has gaps and when extra bits are offered after the last row.

// File: rtl/pla_array_pkg.sv
package pla_array_pkg;

  // Size of the sum-term block for output o: grows by step up to the middle,
  // then mirrors back down.
  function automatic int grp_size(input int o, input int n_out,
                                  input int base, input int step);
    if (o < n_out / 2) return base + step * o;
    return base + step * (n_out - 1 - o);
  endfunction

  // First row of the block for output o (o == n_out gives the total).
  function automatic int grp_offset(input int o, input int n_out,
                                    input int base, input int step);
    int acc;
    acc = 0;
    for (int i = 0; i < o; i++) acc += grp_size(i, n_out, base, step);
    return acc;
  endfunction

endpackage

// File: rtl/pla_cfg_loader.sv
module pla_cfg_loader #(
  parameter int N_LINES = 44,
  parameter int N_TERMS = 133,
  localparam int RW = $clog2(N_TERMS + 1),
  localparam int CW = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               erase,
  input  logic               commit,
  input  logic               cfg_valid,
  input  logic               cfg_data,
  output logic               cfg_ready,
  output logic               eval_en,
  output logic               wr_en,
  output logic [RW-1:0]      wr_row,
  output logic [N_LINES-1:0] wr_data
);

  logic               loading;
  logic [CW-1:0]      bit_cnt;
  logic [RW-1:0]      row_ptr;
  logic [N_LINES-2:0] shreg;
  logic               take;
  logic               row_done;

  assign cfg_ready = loading && (row_ptr < RW'(N_TERMS));
  assign take      = cfg_valid && cfg_ready;
  assign row_done  = take && (bit_cnt == CW'(N_LINES - 1));
  assign wr_data   = {cfg_data, shreg};
  assign wr_row    = row_ptr;
  assign wr_en     = row_done && !erase && !commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading <= 1'b0;
      eval_en <= 1'b0;
      bit_cnt <= '0;
      row_ptr <= '0;
      shreg   <= '0;
    end else if (erase) begin
      loading <= 1'b1;
      eval_en <= 1'b0;
      bit_cnt <= '0;
      row_ptr <= '0;
    end else if (loading && commit) begin
      loading <= 1'b0;
      eval_en <= 1'b1;
      bit_cnt <= '0;
    end else if (take) begin
      shreg <= wr_data[N_LINES-1:1];
      if (row_done) begin
        bit_cnt <= '0;
        row_ptr <= row_ptr + RW'(1);
      end else begin
        bit_cnt <= bit_cnt + CW'(1);
      end
    end
  end

  p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    row_ptr <= RW'(N_TERMS));

  p_row_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && bit_cnt == CW'(N_LINES - 1) && !erase && !commit)
      |=> row_ptr == $past(row_ptr) + RW'(1));

  p_enable_from_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eval_en) |-> $past(commit) && $past(loading));

endmodule

// File: rtl/pla_term_store.sv
module pla_term_store #(
  parameter int N_LINES = 44,
  parameter int N_TERMS = 133,
  localparam int RW = $clog2(N_TERMS + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            erase,
  input  logic                            wr_en,
  input  logic [RW-1:0]                   wr_row,
  input  logic [N_LINES-1:0]              wr_data,
  output logic [N_TERMS-1:0][N_LINES-1:0] map
);

  for (genvar r = 0; r < N_TERMS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (erase)                          map[r] <= '0;
      else if (wr_en && wr_row == RW'(r)) map[r] <= wr_data;
    end
  end

  p_erase_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> map == '0);

endmodule

// File: rtl/pla_term_eval.sv
module pla_term_eval #(
  parameter int N_SIG   = 22,
  parameter int N_TERMS = 133,
  localparam int N_LINES = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]                sig,
  input  logic [N_TERMS-1:0][N_LINES-1:0] map,
  output logic [N_TERMS-1:0]              term
);

  logic [N_LINES-1:0] lines;

  for (genvar k = 0; k < N_SIG; k++) begin : g_line
    assign lines[2*k]   = sig[k];
    assign lines[2*k+1] = ~sig[k];
  end

  // An open connection forces its position to 1; a closed one passes the line.
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    assign term[t] = &(~map[t] | lines);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_OUT    = 10,
  parameter int GRP_BASE = 8,
  parameter int GRP_STEP = 2,
  parameter int N_TERMS  = 133
) (
  input  logic               en,
  input  logic [N_TERMS-1:0] term,
  output logic [N_OUT-1:0]   sum
);
  import pla_array_pkg::*;

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    localparam int OFF = grp_offset(o, N_OUT, GRP_BASE, GRP_STEP);
    localparam int SZ  = grp_size(o, N_OUT, GRP_BASE, GRP_STEP);
    assign sum[o] = en & (|term[OFF +: SZ]);
  end

endmodule

// File: rtl/pla_and_or_array.sv
module pla_and_or_array #(
  parameter int N_DED    = 12,
  parameter int N_FB     = 10,
  parameter int GRP_BASE = 8,
  parameter int GRP_STEP = 2,
  localparam int N_OUT   = N_FB,
  localparam int N_SIG   = N_DED + N_FB,
  localparam int N_LINES = 2 * N_SIG,
  localparam int N_SUM   = pla_array_pkg::grp_offset(N_OUT, N_OUT, GRP_BASE, GRP_STEP),
  localparam int ROW_OE  = N_SUM,
  localparam int ROW_PRE = N_SUM + N_OUT,
  localparam int ROW_CLR = ROW_PRE + 1,
  localparam int ROW_CLK = ROW_PRE + 2,
  localparam int N_TERMS = ROW_PRE + 3,
  localparam int RW      = $clog2(N_TERMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase,
  input  logic             commit,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic             cfg_data,
  input  logic [N_DED-1:0] in_ded,
  input  logic [N_FB-1:0]  in_fb,
  output logic [N_OUT-1:0] sum_out,
  output logic [N_OUT-1:0] oe_out,
  output logic             preset_term,
  output logic             clear_term,
  output logic             clock_term
);

  logic                            eval_en;
  logic                            wr_en;
  logic [RW-1:0]                   wr_row;
  logic [N_LINES-1:0]              wr_data;
  logic [N_TERMS-1:0][N_LINES-1:0] map;
  logic [N_TERMS-1:0]              term;

  pla_cfg_loader #(.N_LINES(N_LINES), .N_TERMS(N_TERMS)) u_loader (
    .clk(clk), .rst_n(rst_n), .erase(erase), .commit(commit),
    .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_ready(cfg_ready),
    .eval_en(eval_en), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data)
  );

  pla_term_store #(.N_LINES(N_LINES), .N_TERMS(N_TERMS)) u_store (
    .clk(clk), .rst_n(rst_n), .erase(erase), .wr_en(wr_en),
    .wr_row(wr_row), .wr_data(wr_data), .map(map)
  );

  pla_term_eval #(.N_SIG(N_SIG), .N_TERMS(N_TERMS)) u_eval (
    .sig({in_fb, in_ded}), .map(map), .term(term)
  );

  pla_or_plane #(.N_OUT(N_OUT), .GRP_BASE(GRP_BASE), .GRP_STEP(GRP_STEP),
                 .N_TERMS(N_TERMS)) u_or (
    .en(eval_en), .term(term), .sum(sum_out)
  );

  assign oe_out      = eval_en ? term[ROW_OE +: N_OUT] : '0;
  assign preset_term = eval_en & term[ROW_PRE];
  assign clear_term  = eval_en & term[ROW_CLR];
  assign clock_term  = eval_en & term[ROW_CLK];

  p_load_blocks_eval_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> !eval_en);

  p_erase_enters_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> cfg_ready && !eval_en);

  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> (sum_out == '0) && (oe_out == '0) && !preset_term);

endmodule

// File: tb/test_pla_and_or_array.sv
module test_pla_and_or_array;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 133;

  typedef struct packed {
    logic [9:0] sum;
    logic [9:0] oe;
    logic       pre;
    logic       clr;
    logic       ck;
  } out_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        erase = 1'b0, commit = 1'b0, cfg_valid = 1'b0, cfg_data = 1'b0;
  logic        cfg_ready;
  logic [11:0] in_ded = '0;
  logic [9:0]  in_fb = '0;
  logic [9:0]  sum_out, oe_out;
  logic        preset_term, clear_term, clock_term;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [43:0] exp_map [NT];
  bit          model_en = 0;
  out_t        exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_and_or_array i_pla_and_or_array (
    .clk(clk), .rst_n(rst_n), .erase(erase), .commit(commit),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .in_ded(in_ded), .in_fb(in_fb), .sum_out(sum_out), .oe_out(oe_out),
    .preset_term(preset_term), .clear_term(clear_term), .clock_term(clock_term)
  );

  function automatic out_t model(logic [11:0] d, logic [9:0] f);
    logic [21:0]   s;
    logic [NT-1:0] t;
    out_t          r;
    int            off, sz;
    logic          v;
    s = {f, d};
    for (int row = 0; row < NT; row++) begin
      t[row] = 1'b1;
      for (int l = 0; l < 44; l++) begin
        v = (l % 2 == 1) ? ~s[l/2] : s[l/2];
        if (exp_map[row][l] && !v) t[row] = 1'b0;
      end
    end
    off = 0;
    for (int o = 0; o < 10; o++) begin
      sz = (o < 5) ? 8 + 2*o : 26 - 2*o;
      r.sum[o] = 1'b0;
      for (int k = 0; k < sz; k++) r.sum[o] |= t[off+k];
      off += sz;
      r.oe[o] = t[120+o];
    end
    r.pre = t[130];
    r.clr = t[131];
    r.ck  = t[132];
    if (!model_en) r = '0;
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Driver: applies a vector and queues the expected output bundle.
  task automatic drive_vec(logic [11:0] d, logic [9:0] f, string tag);
    @(negedge clk);
    in_ded = d;
    in_fb  = f;
    exp_q.push_back(model(d, f));
    tag_q.push_back(tag);
  endtask

  // Monitor: compares the design against the queued expectations.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        out_t  e, a;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        a  = {sum_out, oe_out, preset_term, clear_term, clock_term};
        check(a == e, tg, 64'(a), 64'(e));
      end
    end
  end

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic do_erase();
    pulse(erase);
    for (int r = 0; r < NT; r++) exp_map[r] = '0;
    model_en = 0;
  endtask

  task automatic do_commit();
    pulse(commit);
    model_en = 1;
  endtask

  // Streams bits with gaps in cfg_valid; a bit counts only when ready was seen.
  task automatic send_bits(logic [43:0] r, int n);
    for (int b = 0; b < n; b++) begin
      bit acc;
      acc = 0;
      while (!acc) begin
        @(negedge clk);
        cfg_data  = r[b];
        cfg_valid = ($urandom % 4) != 0;
        acc = cfg_valid && cfg_ready;
      end
    end
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic vectors(int n, string tag);
    drive_vec('0, '0, tag);
    drive_vec('1, '1, tag);
    for (int i = 0; i < n; i++) drive_vec(12'($urandom), 10'($urandom), tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({cfg_ready, sum_out, oe_out, preset_term, clear_term, clock_term} == '0,
          "R1 reset state", 64'({cfg_ready, sum_out, oe_out}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_ready == 1'b0, "R1 ready low after reset", 64'(cfg_ready), 64'(0));

    // Erase, then commit at once: every term open, every output 1.
    do_erase();
    check(cfg_ready == 1'b1, "R2 ready after erase", 64'(cfg_ready), 64'(1));
    drive_vec(12'h5a5, 10'h2c3, "R2 outputs off while loading");
    do_commit();
    check(cfg_ready == 1'b0, "R5 ready low after commit", 64'(cfg_ready), 64'(0));
    vectors(3, "R8 open terms true");

    // Full load of a map with chosen rows; the rest fully closed (R11).
    do_erase();
    for (int r = 0; r < NT; r++) exp_map[r] = '1;
    exp_map[0]   = '0; exp_map[0][0] = 1; exp_map[0][2] = 1;           // d0 & d1
    exp_map[1]   = '0; exp_map[1][31] = 1;                             // ~fb3
    exp_map[29]  = '0; exp_map[29][8] = 1; exp_map[29][10] = 1; exp_map[29][27] = 1;
    exp_map[44]  = '0; exp_map[44][4] = 1; exp_map[44][7] = 1;         // d2 & ~d3
    exp_map[59]  = '0; exp_map[59][42] = 1;                            // fb9
    exp_map[60]  = '0; exp_map[60][0] = 1; exp_map[60][1] = 1;         // R7
    exp_map[112] = '0;                                                 // R8
    exp_map[120] = '0; exp_map[120][24] = 1;                           // oe0 = fb0
    exp_map[130] = '0; exp_map[130][22] = 1;                           // d11
    exp_map[131] = '0; exp_map[131][23] = 1;                           // ~d11
    exp_map[132] = '0;
    for (int r = 0; r < NT; r++) send_bits(exp_map[r], 44);
    check(cfg_ready == 1'b0, "R4 ready low when full", 64'(cfg_ready), 64'(0));
    for (int i = 0; i < 44; i++) begin
      @(negedge clk); cfg_valid = 1'b1; cfg_data = i[0];
    end
    @(negedge clk); cfg_valid = 1'b0;
    check(cfg_ready == 1'b0, "R4 ready stays low", 64'(cfg_ready), 64'(0));
    do_commit();
    vectors(40, "R3 R6 R7 R9 R10 R11 R4 full map");
    drive_vec(12'h003, 10'h000, "R6 d0&d1 drives sum0");
    drive_vec(12'h004, 10'h200, "R9 group4 ends at row 59");
    drive_vec(12'h800, 10'h001, "R10 preset and oe0");

    // Commit outside load mode is ignored.
    pulse(commit);
    vectors(4, "R5 commit ignored when not loading");

    // Partial load: one row plus an unfinished row, then commit.
    do_erase();
    drive_vec(12'hfff, 10'h3ff, "R2 outputs off while loading");
    send_bits(44'h1, 44);
    exp_map[0] = 44'h1;
    send_bits(44'h3ff, 10);
    do_commit();
    vectors(6, "R5 partial row discarded");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule